// File: doc/BRIEF.md
# Bank-Qualified Address Decoder

This block is the glue decoder for a processor that drives a 24-bit address as a bank byte, multiplexed on the data bus, plus a 16-bit address. While PHI2 is low, a transparent latch takes the bank byte from the data bus. While PHI2 is high, the latch holds that byte. The decoder combines the held bank with A15..A0 and drives active-low chip selects for four targets: a 32 KB SRAM, a 32 KB EPROM, a 4 KB I/O window split into eight 512-byte device selects, and extended memory.

Bank zero carries the SRAM in its lower half and the EPROM in its upper half. The I/O window at $D000-$DFFF in bank zero overrides the EPROM. The window is compared against all 24 address bits, so it does not repeat in higher banks. Any non-zero bank goes to extended memory alone. Read and write strobes come from gating R/W with PHI2. The selects are combinational from the inputs and the held bank, so they add no clock cycle.

Top module: `bank_addr_decoder`

## Requirements
- R1: While PHI2 is low, the bank latch follows the data bus. While PHI2 is high, it holds the value from the end of the low phase, and data bus changes have no effect on the selects. While res_n is low, the bank is forced to zero.
- R2: `sram_cs_n` is low exactly when the bank is zero and A15 is 0.
- R3: `rom_cs_n` is low exactly when the bank is zero, A15 is 1, and A15..A12 is not 4'b1101.
- R4: With bank zero and A15..A12 equal to 4'b1101, `io_cs_n[k]` is low for k = A11..A9, and the other seven I/O selects are high.
- R5: With a non-zero bank, only `xmem_cs_n` is low. This includes addresses whose low 16 bits fall in $D000-$DFFF, such as $E0D000.
- R6: Of the 11 select outputs (sram, rom, xmem and the 8 I/O bits), exactly one is low at all times.
- R7: `rd_n` is low exactly when R/W=1 and PHI2=1. `wr_n` is low exactly when R/W=0 and PHI2=1.
- R8: A change of address during PHI2 high moves the selects with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | Bus phase clock. Low: bank capture. High: data phase. |
| res_n | input | 1 | Active-low reset; forces the bank to zero |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | A15..A0 |
| data | input | 8 | Data bus; carries the bank byte while PHI2 is low |
| sram_cs_n | output | 1 | SRAM select |
| rom_cs_n | output | 1 | EPROM select |
| io_cs_n | output | 8 | I/O device selects |
| xmem_cs_n | output | 1 | Extended memory select |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |

## Verification
Two things can happen in the same PHI2-high phase: the data bus changes to carry write or read data, and the decoder resolves an I/O or memory access. Each scenario loads a bank during the low phase. It then inverts the data bus right after PHI2 rises and checks the selects and strobes against values computed from the latched bank. Any leak of the new data into the latch would move the select to a wrong target. The $E0D000 alias case and a bank-zero $D000 access are run in adjacent cycles, so that both the bank and the window decode switch.

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder #(
  parameter int BANK_W = 8,
  parameter int IO_SEL = 8
) (
  input  logic              phi2,
  input  logic              res_n,
  input  logic              rw,
  input  logic [15:0]       addr,
  input  logic [BANK_W-1:0] data,
  output logic              sram_cs_n,
  output logic              rom_cs_n,
  output logic [IO_SEL-1:0] io_cs_n,
  output logic              xmem_cs_n,
  output logic              rd_n,
  output logic              wr_n
);
  localparam int SEL_W = $clog2(IO_SEL);

  logic [BANK_W-1:0] bank_q;
  logic              bank0, in_io, io_hit;
  logic [SEL_W-1:0]  dev;

  always_latch begin
    if (!res_n)     bank_q <= '0;
    else if (!phi2) bank_q <= data;
  end

  assign bank0  = (bank_q == '0);
  assign in_io  = (addr[15:12] == 4'b1101);
  assign io_hit = bank0 && in_io;
  assign dev    = addr[11 -: SEL_W];

  assign sram_cs_n = !(bank0 && !addr[15]);
  assign rom_cs_n  = !(bank0 && addr[15] && !in_io);
  assign xmem_cs_n = bank0;

  for (genvar k = 0; k < IO_SEL; k++) begin : g_io
    assign io_cs_n[k] = !(io_hit && (dev == SEL_W'(k)));
  end

  assign rd_n = !(phi2 && rw);
  assign wr_n = !(phi2 && !rw);

  assert_one_select_R6: assert property (@(negedge phi2) disable iff (!res_n)
    $countones({sram_cs_n, rom_cs_n, xmem_cs_n, io_cs_n}) == IO_SEL + 2);

  assert_io_onehot_R4: assert property (@(negedge phi2) disable iff (!res_n)
    $onehot0(~io_cs_n));

  assert_io_needs_window_R4: assert property (@(negedge phi2) disable iff (!res_n)
    (io_cs_n != '1) |-> (addr[15:12] == 4'b1101));

  assert_bank_isolates_R5: assert property (@(negedge phi2) disable iff (!res_n)
    (!xmem_cs_n) |-> (sram_cs_n && rom_cs_n && io_cs_n == '1));

  assert_strobes_R7: assert property (@(negedge phi2) disable iff (!res_n)
    (rd_n != wr_n) && (rd_n == !rw));

  assert_sram_low_half_R2: assert property (@(negedge phi2) disable iff (!res_n)
    (!sram_cs_n) |-> !addr[15]);
endmodule

// File: tb/test_bank_addr_decoder.sv
`timescale 1ns/1ps
module test_bank_addr_decoder;
  logic        phi2 = 1'b0;
  logic        res_n = 1'b0;
  logic        rw = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        sram_cs_n, rom_cs_n, xmem_cs_n, rd_n, wr_n;
  logic [7:0]  io_cs_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  bank_addr_decoder i_bank_addr_decoder (
    .phi2(phi2), .res_n(res_n), .rw(rw), .addr(addr), .data(data),
    .sram_cs_n(sram_cs_n), .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n),
    .xmem_cs_n(xmem_cs_n), .rd_n(rd_n), .wr_n(wr_n));

  always #2 phi2 = ~phi2;

  function automatic logic [10:0] expect_sel(input logic [7:0] b, input logic [15:0] a);
    logic [10:0] v = '1;
    if (b != 0) v[0] = 1'b0;
    else if (a < 16'h8000) v[10] = 1'b0;
    else if (a >= 16'hD000 && a <= 16'hDFFF) v[1 + a[11:9]] = 1'b0;
    else v[9] = 1'b0;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [10:0] sel_now();
    return {sram_cs_n, rom_cs_n, io_cs_n, xmem_cs_n};
  endfunction

  task automatic access(input string req, input logic [7:0] b, input logic [15:0] a, input logic r);
    @(negedge phi2);
    data = b; addr = a; rw = r;
    #1;
    check({req, "/R7 low phase"}, {rd_n, wr_n}, 2'b11);
    @(posedge phi2);
    #0.4 data = ~b;
    #0.6;
    check({req, " sel"}, sel_now(), expect_sel(b, a));
    check({req, "/R7 strobes"}, {rd_n, wr_n}, r ? 2'b01 : 2'b10);
  endtask

  task automatic t_reset();
    data = 8'hFF; addr = 16'h0123;
    #3;
    check("R1 reset bank zero", sel_now(), expect_sel(8'h00, 16'h0123));
    res_n = 1'b1;
  endtask

  task automatic t_sram();
    access("R2", 8'h00, 16'h0000, 1'b1);
    access("R2", 8'h00, 16'h7FFF, 1'b0);
  endtask

  task automatic t_rom();
    access("R3", 8'h00, 16'h8000, 1'b1);
    access("R3", 8'h00, 16'hCFFF, 1'b1);
    access("R3", 8'h00, 16'hE000, 1'b0);
    access("R3", 8'h00, 16'hFFFF, 1'b1);
  endtask

  task automatic t_io();
    for (int k = 0; k < 8; k++)
      access("R4", 8'h00, 16'hD000 + 16'(k * 512) + 16'h1F, k[0]);
    access("R4", 8'h00, 16'hDFFF, 1'b1);
  endtask

  task automatic t_xmem();
    access("R5 alias", 8'hE0, 16'hD000, 1'b1);
    access("R4 after alias", 8'h00, 16'hD000, 1'b1);
    access("R5", 8'h01, 16'h0000, 1'b0);
    access("R5", 8'h80, 16'hFFFF, 1'b1);
  endtask

  task automatic t_hold();
    @(negedge phi2);
    data = 8'h00; addr = 16'hD200;
    @(posedge phi2);
    #0.3 data = 8'h5A;
    #0.3 addr = 16'h1000;
    #0.2;
    check("R8 same-phase addr change", sel_now(), expect_sel(8'h00, 16'h1000));
    check("R1 hold while high", xmem_cs_n, 1'b1);
    @(negedge phi2);
    #0.5;
    check("R1 transparent low", sel_now(), expect_sel(8'h5A, 16'h1000));
  endtask

  task automatic t_exclusive();
    for (int i = 0; i < 64; i++) begin
      logic [7:0] b = (i % 5 == 0) ? 8'(i * 37) : 8'h00;
      access("R6", b, 16'(i * 16'h0413), i[0]);
      check("R6 count", 32'($countones(sel_now())), 32'd10);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sram();
    t_rom();
    t_io();
    t_xmem();
    t_hold();
    t_exclusive();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule